// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller

This block collects interrupt requests from four fixed sources (keyboard, timer, power fail and machine check) and decides, at each instruction boundary, whether the running process must be interrupted. Each source has a fixed 3-bit priority, its own pending flag and its own enable bit. The controller models the 16-bit processor status word, which holds the privilege level, the priority of the running process and the condition codes. The controller's decision rests on the priority field of that word.

At a clock edge where the boundary strobe is high, the controller picks the highest-priority source that is both pending and enabled. It raises a one-cycle take pulse only if that source's priority is strictly above the running priority. With the pulse it presents the winner's priority, so that the surrounding processor can load it into the status word, and a per-source 8-bit vector index. Requests arrive as plain level or pulse inputs and are held as pending flags until software clears them through per-source clear inputs. All pins are plain control and status pins. None of them carries a stream, so no valid/ready handshake or back-pressure applies.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A request input high at a clock edge sets that source's pending flag (pend_o), and the flag stays set until cleared.
- R2: A clear input high at an edge deasserts that source's pending flag, unless the same source's request is also high at that edge, in which case the flag stays set.
- R3: Enable bits are loaded from en_data_i when en_wr_i is high. A pending source whose enable bit is 0 is never taken and stays pending.
- R4: The source priorities are fixed: keyboard (bit 0) is 4, timer (bit 1) is 5, power fail (bit 2) is 6 and machine check (bit 3) is 7. The vector index is 0x40 plus the bit number.
- R5: When several enabled sources are pending, the one with the highest priority wins.
- R6: A take occurs only when the winner's priority is strictly greater than status bits [10:8]. An equal priority is not taken.
- R7: take_o is high for exactly the cycle after a clock edge at which boundary_i was high. It uses the pending, enable and status state held before that edge.
- R8: Writing the status word with psr_wr_i keeps bit 15 (privilege, 0 kernel, 1 user), bits [10:8] (running priority) and bits [2:0] (condition codes N, Z, P). All other bits read as 0.
- R9: Reset clears all pending flags, all enable bits and take_o, and sets the status word to 0x8000 (user mode, priority 0).
- R10: While take_o is low, take_prio_o and take_vec_o read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Request per source (bit 0 keyboard, 1 timer, 2 power fail, 3 machine check) |
| clr_i | input | 4 | Clear of the pending flag, per source |
| en_wr_i | input | 1 | Load the enable bits |
| en_data_i | input | 4 | New enable bits |
| psr_wr_i | input | 1 | Load the status word |
| psr_data_i | input | 16 | New status word |
| boundary_i | input | 1 | Instruction boundary strobe |
| pend_o | output | 4 | Pending flags |
| psr_o | output | 16 | Current status word |
| take_o | output | 1 | Interrupt take pulse |
| take_prio_o | output | 3 | Priority of the taken source |
| take_vec_o | output | 8 | Vector index of the taken source |

## Verification
Directed cases come first. A request pending while disabled separates enable gating from pending tracking. A running priority equal to the winner's separates a strict comparison from a greater-or-equal one. Two high sources arriving together separate the priority order from the order of arrival. A clear that coincides with a request shows which of the two wins. Long random runs then mix sparse requests, clears, enable rewrites, status writes with junk bits and irregular boundary strobes. These runs show whether the take decision really uses the state held before the edge, and not the values being written at it.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SW_W      = 16;
  localparam int PRIV_BIT  = 15;
  localparam int PRIO_LSB  = 8;
  localparam int PRIO_W    = 3;
  localparam int CC_W      = 3;

  localparam logic [SW_W-1:0] SW_KEEP_MASK =
    (SW_W'(1) << PRIV_BIT) | (SW_W'((1 << PRIO_W) - 1) << PRIO_LSB) | SW_W'((1 << CC_W) - 1);

  localparam logic [SW_W-1:0] SW_RESET = SW_W'(1) << PRIV_BIT;

  typedef struct packed {
    logic              hit;
    logic [PRIO_W-1:0] prio;
    logic [7:0]        vec;
  } take_t;

  function automatic logic [PRIO_W-1:0] sw_prio(input logic [SW_W-1:0] sw);
    return sw[PRIO_LSB +: PRIO_W];
  endfunction
endpackage

// File: rtl/irq_pend.sv
module irq_pend #(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] req_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (!rst_n)
        pend_q[g] <= 1'b0;
      else if (req_i[g])
        pend_q[g] <= 1'b1;
      else if (clr_i[g])
        pend_q[g] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_wr_i,
  input  logic [NSRC-1:0] en_data_i,
  input  logic            psr_wr_i,
  input  logic [SW_W-1:0] psr_data_i,
  output logic [NSRC-1:0] en_o,
  output logic [SW_W-1:0] psr_o
);
  logic [NSRC-1:0] en_q;
  logic [SW_W-1:0] psr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      en_q <= '0;
    else if (en_wr_i)
      en_q <= en_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      psr_q <= SW_RESET;
    else if (psr_wr_i)
      psr_q <= psr_data_i & SW_KEEP_MASK;
  end

  assign en_o  = en_q;
  assign psr_o = psr_q;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_pkg::*;
#(
  parameter int         NSRC      = 4,
  parameter int         PRIO_BASE = 4,
  parameter logic [7:0] VEC_BASE  = 8'h40,
  localparam int        IDX_W     = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]   elig_i,
  output logic              win_valid_o,
  output logic [IDX_W-1:0]  win_idx_o,
  output logic [PRIO_W-1:0] win_prio_o,
  output logic [7:0]        win_vec_o
);
  logic [PRIO_W-1:0] prio_tab [NSRC];
  logic [7:0]        vec_tab  [NSRC];

  for (genvar g = 0; g < NSRC; g++) begin : g_tab
    assign prio_tab[g] = PRIO_W'(PRIO_BASE + g);
    assign vec_tab[g]  = VEC_BASE + 8'(g);
  end

  // Priority rises with the source index, so the highest set bit wins.
  always_comb begin
    win_valid_o = 1'b0;
    win_idx_o   = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (elig_i[i]) begin
        win_valid_o = 1'b1;
        win_idx_o   = IDX_W'(i);
      end
    end
  end

  assign win_prio_o = win_valid_o ? prio_tab[win_idx_o] : '0;
  assign win_vec_o  = win_valid_o ? vec_tab[win_idx_o]  : '0;
endmodule

// File: rtl/irq_take.sv
module irq_take
  import irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic              win_valid_i,
  input  logic [PRIO_W-1:0] win_prio_i,
  input  logic [7:0]        win_vec_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  output take_t             take_o
);
  take_t take_q, take_d;

  always_comb begin
    take_d = '0;
    if (boundary_i && win_valid_i && (win_prio_i > run_prio_i)) begin
      take_d.hit  = 1'b1;
      take_d.prio = win_prio_i;
      take_d.vec  = win_vec_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      take_q <= '0;
    else
      take_q <= take_d;
  end

  assign take_o = take_q;
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int         NSRC      = 4,
  parameter int         PRIO_BASE = 4,
  parameter logic [7:0] VEC_BASE  = 8'h40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [NSRC-1:0]   clr_i,
  input  logic              en_wr_i,
  input  logic [NSRC-1:0]   en_data_i,
  input  logic              psr_wr_i,
  input  logic [SW_W-1:0]   psr_data_i,
  input  logic              boundary_i,
  output logic [NSRC-1:0]   pend_o,
  output logic [SW_W-1:0]   psr_o,
  output logic              take_o,
  output logic [PRIO_W-1:0] take_prio_o,
  output logic [7:0]        take_vec_o
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]   pend_q;
  logic [NSRC-1:0]   en_q;
  logic [SW_W-1:0]   psr_q;
  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic [7:0]        win_vec;
  take_t             take_q;

  irq_pend #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i), .pend_o(pend_q)
  );

  irq_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .en_wr_i(en_wr_i), .en_data_i(en_data_i),
    .psr_wr_i(psr_wr_i), .psr_data_i(psr_data_i),
    .en_o(en_q), .psr_o(psr_q)
  );

  irq_arb #(.NSRC(NSRC), .PRIO_BASE(PRIO_BASE), .VEC_BASE(VEC_BASE)) u_arb (
    .elig_i(pend_q & en_q),
    .win_valid_o(win_valid), .win_idx_o(win_idx),
    .win_prio_o(win_prio), .win_vec_o(win_vec)
  );

  irq_take u_take (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i),
    .win_valid_i(win_valid), .win_prio_i(win_prio), .win_vec_i(win_vec),
    .run_prio_i(sw_prio(psr_q)), .take_o(take_q)
  );

  assign pend_o      = pend_q;
  assign psr_o       = psr_q;
  assign take_o      = take_q.hit;
  assign take_prio_o = take_q.prio;
  assign take_vec_o  = take_q.vec;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk
  import irq_pkg::*;
#(
  parameter int         NSRC      = 4,
  parameter int         PRIO_BASE = 4,
  parameter logic [7:0] VEC_BASE  = 8'h40
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NSRC-1:0]   req_i,
  input logic [NSRC-1:0]   clr_i,
  input logic              boundary_i,
  input logic [NSRC-1:0]   en,
  input logic [NSRC-1:0]   pend_o,
  input logic [SW_W-1:0]   psr_o,
  input logic              take_o,
  input logic [PRIO_W-1:0] take_prio_o,
  input logic [7:0]        take_vec_o
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0]  elig_d;
  logic [IDX_W-1:0] tk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) elig_d <= '0;
    else        elig_d <= en & pend_o;
  end

  assign tk_idx = IDX_W'(take_vec_o - VEC_BASE);

  AST_REQ_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(req_i) & ~pend_o) == '0));                                         // R1
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_o & $past(clr_i & ~req_i)) == '0));                                 // R2
  AST_TAKE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> elig_d[tk_idx]);                                                // R3
  AST_VEC_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (take_vec_o == VEC_BASE + 8'(take_prio_o - PRIO_W'(PRIO_BASE)))); // R4
  AST_HIGHEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> ((elig_d >> tk_idx) == NSRC'(1)));                              // R5
  AST_STRICT_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (take_prio_o > $past(sw_prio(psr_o))));                         // R6
  AST_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> $past(boundary_i));                                             // R7
  AST_PSR_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (psr_o == SW_RESET && pend_o == '0 && !take_o));          // R9
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !take_o |-> (take_prio_o == '0 && take_vec_o == '0));                      // R10
endmodule

bind irq_prio_ctrl irq_prio_chk #(.NSRC(NSRC), .PRIO_BASE(PRIO_BASE), .VEC_BASE(VEC_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i), .boundary_i(boundary_i),
  .en(en_q), .pend_o(pend_o), .psr_o(psr_o), .take_o(take_o),
  .take_prio_o(take_prio_o), .take_vec_o(take_vec_o)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  req_i, clr_i, en_data_i;
  logic        en_wr_i, psr_wr_i, boundary_i;
  logic [15:0] psr_data_i;
  logic [3:0]  pend_o;
  logic [15:0] psr_o;
  logic        take_o;
  logic [2:0]  take_prio_o;
  logic [7:0]  take_vec_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0]  m_pend, m_en;
  logic [15:0] m_psr;
  logic [11:0] m_take;   // {hit, prio, vec}

  always #10 clk = ~clk;  // 50 MHz

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .clr_i(clr_i),
    .en_wr_i(en_wr_i), .en_data_i(en_data_i), .psr_wr_i(psr_wr_i),
    .psr_data_i(psr_data_i), .boundary_i(boundary_i), .pend_o(pend_o),
    .psr_o(psr_o), .take_o(take_o), .take_prio_o(take_prio_o), .take_vec_o(take_vec_o)
  );

  function automatic logic [11:0] exp_take(input logic [3:0] pend, input logic [3:0] en,
                                           input logic [15:0] psr, input logic bnd);
    logic [2:0] p;
    logic [11:0] r;
    r = '0;
    for (int i = 3; i >= 0; i--) begin
      p = 3'(4 + i);
      if (r == '0 && pend[i] && en[i] && bnd && p > psr[10:8])
        r = {1'b1, p, 8'h40 + 8'(i)};
      else if (r == '0 && pend[i] && en[i])
        break;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [3:0] rq, input logic [3:0] cl, input logic ew,
                     input logic [3:0] ed, input logic pw, input logic [15:0] pd,
                     input logic bd, input string tag);
    req_i = rq; clr_i = cl; en_wr_i = ew; en_data_i = ed;
    psr_wr_i = pw; psr_data_i = pd; boundary_i = bd;
    m_take = exp_take(m_pend, m_en, m_psr, bd);
    m_pend = (m_pend & ~cl) | rq;
    if (ew) m_en = ed;
    if (pw) m_psr = pd & 16'h8707;
    @(posedge clk);
    @(negedge clk);
    check(pend_o == m_pend, {tag, " pend"}, 32'(pend_o), 32'(m_pend));
    check(psr_o == m_psr, {tag, " psr"}, 32'(psr_o), 32'(m_psr));
    check({take_o, take_prio_o, take_vec_o} == m_take, {tag, " take"},
          32'({take_o, take_prio_o, take_vec_o}), 32'(m_take));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20201106));
    rst_n = 1'b0; req_i = '0; clr_i = '0; en_wr_i = 0; en_data_i = '0;
    psr_wr_i = 0; psr_data_i = '0; boundary_i = 0;
    m_pend = '0; m_en = '0; m_psr = 16'h8000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state, R10 idle outputs
    check(pend_o == 4'h0 && psr_o == 16'h8000, "R9 reset", {pend_o, 12'h0, psr_o}, 32'h0000_8000);
    check(!take_o && take_prio_o == 0 && take_vec_o == 0, "R10 idle", 32'({take_o, take_prio_o, take_vec_o}), 0);
    rst_n = 1'b1;

    // R1 pend without enable; R3 not taken, stays pending
    cyc(4'b0001, 4'b0000, 0, 4'h0, 0, 16'h0, 0, "R1");
    cyc(4'b0000, 4'b0000, 0, 4'h0, 0, 16'h0, 1, "R3");
    check(pend_o == 4'b0001 && !take_o, "R3 disabled held", 32'({pend_o, take_o}), 32'b00010);
    // enable all, boundary: keyboard prio 4 vec 0x40
    cyc(4'b0000, 4'b0000, 1, 4'hF, 0, 16'h0, 0, "R3");
    cyc(4'b0000, 4'b0000, 0, 4'h0, 0, 16'h0, 1, "R7");
    check(take_o && take_prio_o == 3'd4 && take_vec_o == 8'h40, "R4 keyboard", 32'({take_prio_o, take_vec_o}), 32'h440);
    cyc(4'b0000, 4'b0000, 0, 4'h0, 0, 16'h0, 0, "R7");
    check(!take_o && take_vec_o == 0, "R7 one pulse", 32'(take_o), 0);
    // R8 masked status write, running priority 4
    cyc(4'b0000, 4'b0000, 0, 4'h0, 1, 16'h7C7D, 0, "R8");
    check(psr_o == 16'h0405, "R8 fields", 32'(psr_o), 32'h0405);
    // R6 equal priority not taken
    cyc(4'b0000, 4'b0000, 0, 4'h0, 0, 16'h0, 1, "R6");
    check(!take_o, "R6 equal prio", 32'(take_o), 0);
    // timer above running priority
    cyc(4'b0010, 4'b0000, 0, 4'h0, 0, 16'h0, 0, "R1");
    cyc(4'b0000, 4'b0000, 0, 4'h0, 0, 16'h0, 1, "R6");
    check(take_o && take_prio_o == 3'd5 && take_vec_o == 8'h41, "R6 timer", 32'({take_prio_o, take_vec_o}), 32'h541);
    // R5 machine check over power fail
    cyc(4'b1100, 4'b0000, 0, 4'h0, 0, 16'h0, 0, "R1");
    cyc(4'b0000, 4'b0000, 0, 4'h0, 0, 16'h0, 1, "R5");
    check(take_o && take_prio_o == 3'd7 && take_vec_o == 8'h43, "R5 highest", 32'({take_prio_o, take_vec_o}), 32'h743);
    // R2 clear, and clear coinciding with request
    cyc(4'b0000, 4'b1000, 0, 4'h0, 0, 16'h0, 0, "R2");
    check(pend_o == 4'b0111, "R2 clear", 32'(pend_o), 32'h7);
    cyc(4'b0100, 4'b0100, 0, 4'h0, 0, 16'h0, 0, "R2");
    check(pend_o == 4'b0111, "R2 req wins", 32'(pend_o), 32'h7);
    // R3 power fail disabled, timer wins
    cyc(4'b0000, 4'b0000, 1, 4'b0011, 0, 16'h0, 0, "R3");
    cyc(4'b0000, 4'b0000, 0, 4'h0, 0, 16'h0, 1, "R3");
    check(take_o && take_vec_o == 8'h41 && pend_o == 4'b0111, "R3 gated winner",
          32'({pend_o, take_vec_o}), 32'h741);
    cyc(4'b0000, 4'b1111, 0, 4'h0, 0, 16'h0, 0, "R2");

    // random mix (R5 main function)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] rq, cl;
      rq = (($urandom % 4) == 0) ? 4'($urandom) & 4'($urandom) : 4'h0;
      cl = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      cyc(rq, cl, ($urandom % 10) == 0, 4'($urandom), ($urandom % 8) == 0,
          16'($urandom), ($urandom % 3) != 0, "R5");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule